// File: doc/BRIEF.md
# Flash write/erase controller

This block sequences programming and erasure of a small on-chip non-volatile byte array. The array is modelled as a synchronous byte memory. A host drives two ports. The configuration port selects the operation, sets the protection bits and clears the error flag. The flash port carries read and write strobes. Each accepted write strobe starts the operation chosen in the operation register, and the busy output then stays high for a parameterised number of cycles. Programming can only move bits from 1 to 0, so erased bytes read as 0xFF.

A block mode supports streaming many program writes back to back. In this mode a write-ready flag drops while each byte or word is being programmed and returns when that write completes. The first write of a block takes longer than the writes after it. Accesses that break the sequencing rules set a sticky violation flag. When the interrupt enable is set, they also pulse a non-maskable interrupt request. A protection bit silently discards all write strobes.

Top module: `flash_ctrl`

## Requirements
- R1: A legal write in operation 1 (single) or 2 (block) stores old AND new data at `fl_addr`. When `fl_word`=1, it also stores old AND `fl_wdata[15:8]` at address `fl_addr`+1, taken modulo the array size.
- R2: Operation 3 sets every byte of the aligned 2^SEG_AW-byte segment that holds `fl_addr` to 0xFF and leaves all other bytes unchanged.
- R3: Operation 4 sets bytes INFO_BYTES and above to 0xFF only when `fl_addr` >= INFO_BYTES. With a lower address the strobe changes nothing and does not set busy.
- R4: Operation 5 sets every byte of the array to 0xFF.
- R5: While the lock bit (select 1, bit 0) is 1, every flash write strobe is dropped: no data change, no busy, no violation.
- R6: An unlocked write strobe while busy=1 or wr_wait=0 is a violation, unless operation 2 is selected and wr_wait=1. A violating write changes no data.
- R7: A read strobe while busy=1 is a violation and leaves `fl_rdata` unchanged. Otherwise `fl_rdata` takes {byte[addr+1], byte[addr]} at the next edge.
- R8: `viol_flag` is set on the edge after any violation and stays set until a configuration write to select 2 with bit 0 = 1. If a violation and a clear fall in the same cycle, the flag ends up set.
- R9: `nmi_req` is a one-cycle pulse, on the same edge that sets the flag, and only when the interrupt enable (select 1, bit 1) was 1.
- R10: busy is high for exactly T_WR cycles after a single write, T_SEG cycles after a segment erase and T_MASS cycles after a main or full erase, counting from the edge that accepts the strobe.
- R11: In block mode the first write after block entry takes T_BLK1 cycles and later writes take T_BLK cycles. wr_wait is low during each write. busy stays high between writes and falls on the edge after the operation register leaves 2 with no write in progress.
- R12: A legal write strobe while the operation register holds 0, 6 or 7 has no effect.
- R13: After reset: busy=0, wr_wait=1, viol_flag=0, nmi_req=0, fl_rdata=0, every array byte 0xFF, and all configuration fields 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 operation, 1 protection {irq_en, lock}, 2 flag clear |
| cfg_wdata | input | 3 | Configuration write data |
| fl_we | input | 1 | Flash write strobe |
| fl_re | input | 1 | Flash read strobe |
| fl_word | input | 1 | Write covers two bytes |
| fl_addr | input | AW | Byte address |
| fl_wdata | input | 16 | Write data, low byte at fl_addr |
| fl_rdata | output | 16 | Registered read data |
| busy | output | 1 | Operation in progress |
| wr_wait | output | 1 | Ready for the next write |
| viol_flag | output | 1 | Sticky access-violation flag |
| nmi_req | output | 1 | Non-maskable interrupt request pulse |

## Verification
Several pairs of functions can coincide in one cycle. A violation can arrive together with the flag-clear write. A read strobe can share a cycle with a write strobe to the same address. A block-exit configuration write can arrive while a block write is still being programmed. The bench drives each pair in the same cycle. A behavioural reference model in the bench resolves every pair by the stated rules: the set wins over the clear, the read sees the contents from before the write, and the block exit is deferred until the write completes. The bench compares the model with every output on every clock.

// File: rtl/flash_pkg.sv
package flash_pkg;

  typedef enum logic [2:0] {
    OP_OFF    = 3'd0,
    OP_SINGLE = 3'd1,
    OP_BLOCK  = 3'd2,
    OP_SEG    = 3'd3,
    OP_MAIN   = 3'd4,
    OP_ALL    = 3'd5
  } flash_op_e;

  localparam logic [1:0] SEL_OP   = 2'd0;
  localparam logic [1:0] SEL_PROT = 2'd1;
  localparam logic [1:0] SEL_CLR  = 2'd2;

  localparam logic [7:0] ERASED = 8'hFF;

  // programming can only pull bits low
  function automatic logic [7:0] prog_byte(input logic [7:0] old_v, input logic [7:0] new_v);
    return old_v & new_v;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/flash_regs.sv
module flash_regs
  import flash_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [1:0] cfg_sel,
  input  logic [2:0] cfg_wdata,
  input  logic       viol_set,
  output logic [2:0] mode_o,
  output logic       lock_o,
  output logic       irq_en_o,
  output logic       viol_o,
  output logic       nmi_o
);

  logic [2:0] mode_q;
  logic       lock_q, irq_en_q, viol_q, nmi_q;
  logic       flag_clr;

  assign flag_clr = cfg_we && (cfg_sel == SEL_CLR) && cfg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      lock_q   <= 1'b0;
      irq_en_q <= 1'b0;
      viol_q   <= 1'b0;
      nmi_q    <= 1'b0;
    end else begin
      if (cfg_we && cfg_sel == SEL_OP) mode_q <= cfg_wdata;
      if (cfg_we && cfg_sel == SEL_PROT) begin
        lock_q   <= cfg_wdata[0];
        irq_en_q <= cfg_wdata[1];
      end
      viol_q <= viol_set | (viol_q & ~flag_clr);
      nmi_q  <= viol_set & irq_en_q;
    end
  end

  assign mode_o   = mode_q;
  assign lock_o   = lock_q;
  assign irq_en_o = irq_en_q;
  assign viol_o   = viol_q;
  assign nmi_o    = nmi_q;

  assert_viol_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_q && !flag_clr) |=> viol_q);
  assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    viol_set |=> viol_q);
  assert_nmi_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_q |-> (viol_q && $past(irq_en_q)));

endmodule

// File: rtl/flash_timer.sv
module flash_timer #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done,
  output logic          running
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end

  assign done    = (cnt_q == CW'(1));
  assign running = (cnt_q != '0);

  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !load) |=> (cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_pkg::*;
#(
  parameter int AW         = 6,
  parameter int INFO_BYTES = 16,
  parameter int T_WR       = 4,
  parameter int T_BLK1     = 6,
  parameter int T_BLK      = 3,
  parameter int T_SEG      = 32,
  parameter int T_MASS     = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fl_we,
  input  logic          fl_re,
  input  logic [AW-1:0] fl_addr,
  input  logic [2:0]    mode_i,
  input  logic          lock_i,
  output logic          busy_o,
  output logic          wait_o,
  output logic          prog_go,
  output logic          seg_go,
  output logic          main_go,
  output logic          all_go,
  output logic          rd_go,
  output logic          viol_set
);

  localparam int TMAX = max2(max2(max2(T_WR, T_BLK1), max2(T_BLK, T_SEG)), T_MASS);
  localparam int CW   = $clog2(TMAX + 1);
  localparam logic [CW-1:0] D_WR   = CW'(T_WR);
  localparam logic [CW-1:0] D_BLK1 = CW'(T_BLK1);
  localparam logic [CW-1:0] D_BLK  = CW'(T_BLK);
  localparam logic [CW-1:0] D_SEG  = CW'(T_SEG);
  localparam logic [CW-1:0] D_MASS = CW'(T_MASS);
  localparam logic [AW-1:0] INFO_L = AW'(INFO_BYTES);

  flash_op_e     op_c;
  logic          busy_q, wait_q, blk_q;
  logic          is_blk, wr_req, wr_bad, wr_ok, rd_bad, in_main;
  logic          start, done, running, blk_exit;
  logic [CW-1:0] dur;

  assign op_c    = flash_op_e'(mode_i);
  assign is_blk  = (op_c == OP_BLOCK);
  assign in_main = (fl_addr >= INFO_L);

  // write legality
  assign wr_req = fl_we & ~lock_i;
  assign wr_bad = wr_req & (busy_q | ~wait_q) & ~(is_blk & wait_q);
  assign wr_ok  = wr_req & ~wr_bad;

  assign rd_bad   = fl_re & busy_q;
  assign rd_go    = fl_re & ~busy_q;
  assign viol_set = wr_bad | rd_bad;

  always_comb begin
    prog_go = 1'b0;
    seg_go  = 1'b0;
    main_go = 1'b0;
    all_go  = 1'b0;
    dur     = D_WR;
    case (op_c)
      OP_SINGLE: begin prog_go = wr_ok; dur = D_WR; end
      OP_BLOCK:  begin prog_go = wr_ok; dur = blk_q ? D_BLK : D_BLK1; end
      OP_SEG:    begin seg_go  = wr_ok; dur = D_SEG; end
      OP_MAIN:   begin main_go = wr_ok & in_main; dur = D_MASS; end
      OP_ALL:    begin all_go  = wr_ok; dur = D_MASS; end
      default:   ;
    endcase
  end

  assign start    = prog_go | seg_go | main_go | all_go;
  assign blk_exit = blk_q & wait_q & ~is_blk;

  flash_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .load_val (dur),
    .done     (done),
    .running  (running)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wait_q <= 1'b1;
      blk_q  <= 1'b0;
    end else if (start) begin
      busy_q <= 1'b1;
      if (is_blk) begin
        wait_q <= 1'b0;
        blk_q  <= 1'b1;
      end
    end else if (done) begin
      wait_q <= 1'b1;
      if (!(blk_q && is_blk)) begin
        busy_q <= 1'b0;
        blk_q  <= 1'b0;
      end
    end else if (blk_exit) begin
      busy_q <= 1'b0;
      blk_q  <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign wait_o = wait_q;

  assert_lock_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we && lock_i) |-> (!start && !wr_bad));
  assert_start_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy_q) |-> (is_blk && wait_q));
  assert_read_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_re && busy_q) |=> viol_set || $past(viol_set));
  assert_busy_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !done) |=> busy_q);
  assert_wait_implies_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wait_q |-> busy_q);
  assert_onehot_op_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_go, seg_go, main_go, all_go}));

endmodule

// File: rtl/flash_array.sv
module flash_array
  import flash_pkg::*;
#(
  parameter int AW         = 6,
  parameter int SEG_AW     = 3,
  parameter int INFO_BYTES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_go,
  input  logic          seg_go,
  input  logic          main_go,
  input  logic          all_go,
  input  logic          rd_go,
  input  logic          word,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  output logic [15:0]   rdata
);

  localparam int NB = 1 << AW;
  localparam logic [AW-1:0] INFO_L = AW'(INFO_BYTES);

  logic [7:0]    mem_q [NB];
  logic [7:0]    mem_d [NB];
  logic [AW-1:0] addr_hi;
  logic [7:0]    old_lo, old_hi;
  logic [15:0]   rdata_q;

  assign addr_hi = addr + AW'(1);
  assign old_lo  = mem_q[addr];
  assign old_hi  = mem_q[addr_hi];

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      logic [AW-1:0] idx;
      idx      = AW'(i);
      mem_d[i] = mem_q[i];
      if (all_go)
        mem_d[i] = ERASED;
      else if (main_go && idx >= INFO_L)
        mem_d[i] = ERASED;
      else if (seg_go && idx[AW-1:SEG_AW] == addr[AW-1:SEG_AW])
        mem_d[i] = ERASED;
      else if (prog_go && idx == addr)
        mem_d[i] = prog_byte(mem_q[i], wdata[7:0]);
      else if (prog_go && word && idx == addr_hi)
        mem_d[i] = prog_byte(mem_q[i], wdata[15:8]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) mem_q[i] <= ERASED;
      rdata_q <= '0;
    end else begin
      for (int i = 0; i < NB; i++) mem_q[i] <= mem_d[i];
      if (rd_go) rdata_q <= {old_hi, old_lo};
    end
  end

  assign rdata = rdata_q;

  assert_prog_clears_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    prog_go |=> ((mem_q[$past(addr)] & ~$past(old_lo)) == 8'h00));
  assert_seg_erased_R2: assert property (@(posedge clk) disable iff (!rst_n)
    seg_go |=> (mem_q[$past(addr)] == ERASED));
  assert_all_erased_R4: assert property (@(posedge clk) disable iff (!rst_n)
    all_go |=> (mem_q[0] == ERASED && mem_q[NB-1] == ERASED));

endmodule

// File: rtl/flash_ctrl.sv
module flash_ctrl
  import flash_pkg::*;
#(
  parameter int AW         = 6,
  parameter int SEG_AW     = 3,
  parameter int INFO_BYTES = 16,
  parameter int T_WR       = 4,
  parameter int T_BLK1     = 6,
  parameter int T_BLK      = 3,
  parameter int T_SEG      = 32,
  parameter int T_MASS     = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [2:0]    cfg_wdata,
  input  logic          fl_we,
  input  logic          fl_re,
  input  logic          fl_word,
  input  logic [AW-1:0] fl_addr,
  input  logic [15:0]   fl_wdata,
  output logic [15:0]   fl_rdata,
  output logic          busy,
  output logic          wr_wait,
  output logic          viol_flag,
  output logic          nmi_req
);

  logic [2:0] mode_w;
  logic       lock_w, irq_en_w, viol_set_w;
  logic       prog_go_w, seg_go_w, main_go_w, all_go_w, rd_go_w;

  flash_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_wdata(cfg_wdata),
    .viol_set (viol_set_w),
    .mode_o   (mode_w),
    .lock_o   (lock_w),
    .irq_en_o (irq_en_w),
    .viol_o   (viol_flag),
    .nmi_o    (nmi_req)
  );

  flash_seq #(
    .AW(AW), .INFO_BYTES(INFO_BYTES), .T_WR(T_WR), .T_BLK1(T_BLK1),
    .T_BLK(T_BLK), .T_SEG(T_SEG), .T_MASS(T_MASS)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .fl_we   (fl_we),
    .fl_re   (fl_re),
    .fl_addr (fl_addr),
    .mode_i  (mode_w),
    .lock_i  (lock_w),
    .busy_o  (busy),
    .wait_o  (wr_wait),
    .prog_go (prog_go_w),
    .seg_go  (seg_go_w),
    .main_go (main_go_w),
    .all_go  (all_go_w),
    .rd_go   (rd_go_w),
    .viol_set(viol_set_w)
  );

  flash_array #(.AW(AW), .SEG_AW(SEG_AW), .INFO_BYTES(INFO_BYTES)) u_array (
    .clk    (clk),
    .rst_n  (rst_n),
    .prog_go(prog_go_w),
    .seg_go (seg_go_w),
    .main_go(main_go_w),
    .all_go (all_go_w),
    .rd_go  (rd_go_w),
    .word   (fl_word),
    .addr   (fl_addr),
    .wdata  (fl_wdata),
    .rdata  (fl_rdata)
  );

  assert_nmi_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> $past(irq_en_w));

endmodule

// File: tb/flash_ctrl_bench.sv
module flash_ctrl_bench;

  localparam int AW = 6, NB = 64, SEG = 8, INFO = 16;
  localparam int T_WR = 4, T_BLK1 = 6, T_BLK = 3, T_SEG = 32, T_MASS = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, fl_we = 0, fl_re = 0, fl_word = 0;
  logic [1:0] cfg_sel = 0;
  logic [2:0] cfg_wdata = 0;
  logic [AW-1:0] fl_addr = 0;
  logic [15:0] fl_wdata = 0, fl_rdata;
  logic busy, wr_wait, viol_flag, nmi_req;

  always #5 clk = ~clk;

  flash_ctrl u_flash_ctrl (.*);

  int vectors = 0, miscompares = 0;
  string phase = "R13 reset";

  // behavioural reference model
  logic [7:0]  m_mem [NB];
  logic [15:0] m_rd;
  int          m_cnt, m_mode;
  bit          m_busy, m_wait, m_blk, m_lock, m_irq, m_viol, m_nmi;

  always @(posedge clk) begin
    int a, ah, dur;
    bit vset, go, clr;
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 8'hFF;
      m_rd = 0; m_cnt = 0; m_mode = 0;
      m_busy = 0; m_wait = 1; m_blk = 0; m_lock = 0; m_irq = 0; m_viol = 0; m_nmi = 0;
    end else begin
      a = int'(fl_addr); ah = (a + 1) % NB; vset = 0; go = 0; dur = 0;
      if (fl_re) begin
        if (m_busy) vset = 1;
        else m_rd = {m_mem[ah], m_mem[a]};
      end
      if (fl_we && !m_lock) begin
        if ((m_busy || !m_wait) && !(m_mode == 2 && m_wait)) vset = 1;
        else if (m_mode == 1 || m_mode == 2) begin
          m_mem[a] = m_mem[a] & fl_wdata[7:0];
          if (fl_word) m_mem[ah] = m_mem[ah] & fl_wdata[15:8];
          go = 1;
          if (m_mode == 1) dur = T_WR;
          else begin dur = m_blk ? T_BLK : T_BLK1; m_wait = 0; m_blk = 1; end
        end else if (m_mode == 3) begin
          foreach (m_mem[i]) if (i / SEG == a / SEG) m_mem[i] = 8'hFF;
          go = 1; dur = T_SEG;
        end else if (m_mode == 4) begin
          if (a >= INFO) begin
            foreach (m_mem[i]) if (i >= INFO) m_mem[i] = 8'hFF;
            go = 1; dur = T_MASS;
          end
        end else if (m_mode == 5) begin
          foreach (m_mem[i]) m_mem[i] = 8'hFF;
          go = 1; dur = T_MASS;
        end
      end
      if (go) begin
        m_busy = 1; m_cnt = dur;
      end else if (m_cnt == 1) begin
        m_cnt = 0; m_wait = 1;
        if (!(m_blk && m_mode == 2)) begin m_busy = 0; m_blk = 0; end
      end else if (m_cnt > 1) begin
        m_cnt--;
      end else if (m_blk && m_wait && m_mode != 2) begin
        m_busy = 0; m_blk = 0;
      end
      clr = cfg_we && cfg_sel == 2 && cfg_wdata[0];
      m_nmi  = vset && m_irq;
      m_viol = vset || (m_viol && !clr);
      if (cfg_we && cfg_sel == 0) m_mode = int'(cfg_wdata);
      if (cfg_we && cfg_sel == 1) begin m_lock = cfg_wdata[0]; m_irq = cfg_wdata[1]; end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      vectors++;
      if (busy !== m_busy) begin miscompares++;
        $display("FAIL %s busy act=%0b exp=%0b", phase, busy, m_busy); end
      if (wr_wait !== m_wait) begin miscompares++;
        $display("FAIL %s wr_wait act=%0b exp=%0b", phase, wr_wait, m_wait); end
      if (viol_flag !== m_viol) begin miscompares++;
        $display("FAIL %s viol_flag act=%0b exp=%0b", phase, viol_flag, m_viol); end
      if (nmi_req !== m_nmi) begin miscompares++;
        $display("FAIL %s nmi_req act=%0b exp=%0b", phase, nmi_req, m_nmi); end
      if (fl_rdata !== m_rd) begin miscompares++;
        $display("FAIL %s fl_rdata act=%h exp=%h", phase, fl_rdata, m_rd); end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic [1:0] s, input logic [2:0] d);
    cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk) cfg_we = 0;
  endtask

  task automatic wr(input int a, input logic [15:0] d, input logic w);
    fl_we = 1; fl_addr = AW'(a); fl_wdata = d; fl_word = w;
    @(negedge clk) fl_we = 0;
  endtask

  task automatic rd(input int a);
    fl_re = 1; fl_addr = AW'(a);
    @(negedge clk) fl_re = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired in phase %s", phase);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    tick(3); rst_n = 1;
    phase = "R13 reset"; tick(2); rd(7); tick(1);
    phase = "R12 mode off"; wr(20, 16'h0000, 0); tick(2); rd(20); tick(1);
    phase = "R1 program byte"; cfg(0, 1);
    wr(20, 16'h00A5, 0); tick(5); wr(20, 16'h003C, 0); tick(5); rd(20); tick(1);
    phase = "R1 program word"; wr(30, 16'h1234, 1); tick(5); rd(30); tick(1);
    phase = "R1 word wrap"; wr(63, 16'h0F0F, 1); tick(5); rd(63); rd(0); tick(1);
    phase = "R1 read with write same cycle";
    fl_re = 1; fl_we = 1; fl_addr = AW'(33); fl_wdata = 16'h0011; fl_word = 0;
    @(negedge clk) begin fl_re = 0; fl_we = 0; end
    tick(5); rd(33); tick(1);
    phase = "R10 single duration"; wr(40, 16'h007E, 0); tick(6);
    phase = "R6 write while busy"; wr(41, 16'h0000, 0); wr(41, 16'h0000, 0); tick(5); rd(41); tick(1);
    phase = "R8 flag clear"; cfg(2, 1); tick(2);
    phase = "R9 nmi enabled"; cfg(1, 2); wr(42, 16'h0011, 0); wr(42, 16'h0000, 0); tick(5);
    phase = "R8 set beats clear"; wr(43, 16'h0001, 0);
    fl_we = 1; fl_addr = AW'(43); fl_wdata = 0; cfg_we = 1; cfg_sel = 2; cfg_wdata = 1;
    @(negedge clk) begin fl_we = 0; cfg_we = 0; end
    tick(5); cfg(2, 1); cfg(1, 0); tick(1);
    phase = "R9 nmi disabled"; wr(44, 16'h0055, 0); wr(44, 16'h0000, 0); tick(5); cfg(2, 1);
    phase = "R7 read while busy"; wr(45, 16'h0055, 0); rd(45); tick(4); rd(45); tick(1); cfg(2, 1);
    phase = "R2 segment erase"; cfg(0, 3); wr(21, 16'h0000, 0); tick(T_SEG + 1);
    rd(16); rd(20); rd(30); tick(1);
    phase = "R3 main erase ignored"; cfg(0, 1); wr(5, 16'h000F, 0); tick(5);
    cfg(0, 4); wr(5, 16'h0000, 0); tick(2); rd(5); tick(1);
    phase = "R3 main erase"; wr(40, 16'h0000, 0); tick(T_MASS + 1); rd(5); rd(40); rd(30); tick(1);
    phase = "R4 full erase"; cfg(0, 5); wr(0, 16'h0000, 0); tick(T_MASS + 1); rd(5); tick(1);
    phase = "R11 block write"; cfg(0, 2);
    wr(10, 16'h00F0, 0); tick(T_BLK1 + 1); wr(11, 16'h000F, 0); tick(1);
    wr(12, 16'h0000, 0); tick(4); cfg(2, 1);
    wr(12, 16'h3333, 1); cfg(0, 1); tick(6);
    cfg(0, 2); wr(14, 16'h0077, 0); tick(T_BLK1 + 2); cfg(0, 0); tick(2);
    rd(10); rd(12); rd(14); tick(1);
    phase = "R5 lock"; cfg(1, 1); cfg(0, 1); wr(50, 16'h0000, 0); tick(2);
    cfg(1, 0); rd(50); tick(1);
    phase = "R12 reserved mode"; cfg(0, 6); wr(51, 16'h0000, 0); tick(2); rd(51); tick(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule